// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block takes one pending exception per strobe and works out, in a single clock edge, everything the processor state must look like on entry: the fetch address to redirect to, the exception code and coprocessor field of the cause word, the saved return address (general, error-level or debug), the branch-delay flag, the sticky NMI / soft-reset / debug-cause flags, and the next values of the exception-level, error-level, boot-vector, debug-mode and kernel-mode status bits.

The surrounding core holds the live status word. It presents the current status bits, the exception base address, the faulting PC and the delay-slot flag together with the exception identifier, and it raises `exc_valid` for one cycle. On the next cycle `taken` pulses and every output already shows the post-entry state. An identifier the block does not know produces a one-cycle `bad_id` pulse and leaves all state as it was. Interrupt prioritisation, return from exception and full chip reset happen elsewhere.

Identifier encoding: bit 5 clear means a general exception whose 5-bit cause code is bits 4:0. With bit 5 set, the low bits select the special kinds: 0x20 NMI, 0x21 soft reset, 0x22 debug single-step, 0x23 debug interrupt, 0x24 debug instruction break, 0x25 debug breakpoint, 0x26 debug data-break store, 0x27 debug data-break load.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset every output is zero.
- R2: A general exception jumps to base + 0x180. The base is 0xBFC00200 when `bev_in` is set, and `ebase` with bits 9:0 cleared otherwise.
- R3: An interrupt (code 0) with `iv_in` set uses offset 0x200 instead of 0x180.
- R4: A TLB load (code 2) or TLB store (code 3) with `tlb_refill` set and `exl_in` clear uses offset 0x000. With `exl_in` set it uses 0x180.
- R5: A cache error (code 30) uses offset 0x100 when `bev_in` is set and 0x2000_0100 otherwise.
- R6: Only cause codes 0–13, 15, 18, 22–25 and 30 are accepted as general exceptions. An accepted code is copied to `exc_code`, which no other kind writes.
- R7: For a general exception with `exl_in` clear, `epc` becomes PC−4 and `bd` becomes 1 when `in_dslot` is set. Otherwise `epc` becomes PC and `bd` becomes 0. `kmode_out` becomes 1 and `exl_out` becomes 1.
- R8: When `exl_in` is set, no exception writes `epc` or `bd`. A general exception still sets `exl_out`, and `kmode_out` follows `kmode_in`.
- R9: Coprocessor unusable (code 11) writes `cop_num` to `cop_err`. Every other kind leaves `cop_err` unchanged.
- R10: NMI and soft reset save the delay-slot-adjusted PC in `err_epc`. They set `erl_out`, `bev_out`, `kmode_out` and the sticky `nmi_flag` or `srst_flag`, and jump to 0xBFC00000.
- R11: A debug exception sets its sticky bit in `dbg_flags` (bit 0 single-step, 1 interrupt, 2 instruction break, 3 breakpoint, 4 store break, 5 load break). It saves `dbg_epc`, which is the unadjusted PC for single-step and delay-slot-adjusted for the others. It sets `dm_out` and `kmode_out` and jumps to 0xBFC00480.
- R12: An interrupt (id 0) presented while `dm_in` is set is handled as a debug interrupt.
- R13: NMI, soft reset and debug exceptions clear `bd` when `exl_in` is clear and leave it unchanged when `exl_in` is set.
- R14: An unknown identifier pulses `bad_id` for one cycle, does not pulse `taken`, and changes no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | One-cycle strobe: an exception is presented |
| exc_id | input | 6 | Exception identifier (encoding above) |
| pc | input | 32 | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction sits in a branch-delay slot |
| cop_num | input | 2 | Coprocessor number for an unusable fault |
| tlb_refill | input | 1 | TLB fault is a refill (no matching entry) |
| exl_in | input | 1 | Current exception-level bit |
| erl_in | input | 1 | Current error-level bit |
| bev_in | input | 1 | Current boot-vector bit |
| iv_in | input | 1 | Current dedicated-interrupt-vector bit |
| dm_in | input | 1 | Core currently in debug mode |
| kmode_in | input | 1 | Core currently in kernel mode |
| ebase | input | 32 | Exception base address |
| next_pc | output | 32 | Fetch redirect address |
| epc | output | 32 | General return address |
| err_epc | output | 32 | Error-level return address |
| dbg_epc | output | 32 | Debug return address |
| exc_code | output | 5 | Cause exception code |
| cop_err | output | 2 | Cause coprocessor field |
| bd | output | 1 | Cause branch-delay flag |
| exl_out | output | 1 | Next exception-level bit |
| erl_out | output | 1 | Next error-level bit |
| bev_out | output | 1 | Next boot-vector bit |
| dm_out | output | 1 | Next debug-mode state |
| kmode_out | output | 1 | Next kernel-mode state |
| nmi_flag | output | 1 | Sticky NMI status flag |
| srst_flag | output | 1 | Sticky soft-reset status flag |
| dbg_flags | output | 6 | Sticky debug-cause bits |
| taken | output | 1 | One-cycle pulse: exception accepted |
| bad_id | output | 1 | One-cycle pulse: unknown identifier rejected |

## Verification
Two pairs of functions can act on the same strobe. The first pair is the debug-mode redirection of an interrupt and the interrupt-vector offset. The bench presents id 0 with both `dm_in` and `iv_in` set, and expects the debug vector and debug flag, with no 0x200 offset and no change to `exc_code`. The second pair is the refill offset and the exception-level hold. A TLB refill with `exl_in` set must land on offset 0x180 and leave `epc` and `bd` untouched, and this is judged against a previously written `epc` value. The random phase draws every status bit independently, so these overlaps also occur without being aimed at.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    K_GEN = 2'd0,
    K_RST = 2'd1,
    K_DBG = 2'd2,
    K_BAD = 2'd3
  } exc_kind_e;

  localparam int unsigned ID_W    = 6;
  localparam int unsigned CODE_W  = 5;
  localparam int unsigned NDBG    = 6;
  localparam int unsigned DBGIX_W = $clog2(NDBG);

  localparam logic [CODE_W-1:0] C_INT   = 5'd0;
  localparam logic [CODE_W-1:0] C_TLBL  = 5'd2;
  localparam logic [CODE_W-1:0] C_TLBS  = 5'd3;
  localparam logic [CODE_W-1:0] C_CPU   = 5'd11;
  localparam logic [CODE_W-1:0] C_CACHE = 5'd30;

  localparam logic [ID_W-1:0] ID_NMI  = 6'h20;
  localparam logic [ID_W-1:0] ID_SRST = 6'h21;
  localparam logic [ID_W-1:0] ID_DSS  = 6'h22;
  localparam logic [ID_W-1:0] ID_DINT = 6'h23;
  localparam logic [ID_W-1:0] ID_LAST = 6'h27;

  function automatic logic code_known(input logic [CODE_W-1:0] c);
    case (c)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd15,
      5'd18, 5'd22, 5'd23, 5'd24, 5'd25, 5'd30: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic [ID_W-1:0]    id,
  input  logic               dm_in,
  output exc_kind_e          kind,
  output logic [CODE_W-1:0]  code,
  output logic [DBGIX_W-1:0] dbg_idx,
  output logic               is_srst,
  output logic               is_dss
);
  logic [ID_W-1:0] eff;

  always_comb begin
    eff = id;
    if (id == {1'b0, C_INT} && dm_in) eff = ID_DINT;
  end

  always_comb begin
    code    = eff[CODE_W-1:0];
    is_srst = (eff == ID_SRST);
    is_dss  = (eff == ID_DSS);
    dbg_idx = DBGIX_W'(eff[2:0] - 3'd2);
    if (!eff[ID_W-1])
      kind = code_known(code) ? K_GEN : K_BAD;
    else if (eff > ID_LAST)
      kind = K_BAD;
    else if (eff == ID_NMI || eff == ID_SRST)
      kind = K_RST;
    else
      kind = K_DBG;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  exc_kind_e         kind,
  input  logic [CODE_W-1:0] code,
  input  logic              bev,
  input  logic              iv,
  input  logic              exl,
  input  logic              refill,
  input  logic [W-1:0]      ebase,
  output logic [W-1:0]      vec
);
  localparam logic [W-1:0] BOOT_GEN  = W'(32'hBFC0_0200);
  localparam logic [W-1:0] BOOT_RST  = W'(32'hBFC0_0000);
  localparam logic [W-1:0] BOOT_DBG  = W'(32'hBFC0_0480);
  localparam logic [W-1:0] BASE_MASK = ~W'(32'h3FF);

  logic [W-1:0] base, offs;

  always_comb begin
    base = bev ? BOOT_GEN : (ebase & BASE_MASK);
    if (code == C_CACHE)
      offs = bev ? W'(32'h100) : W'(32'h2000_0100);
    else if (code == C_INT && iv)
      offs = W'(32'h200);
    else if ((code == C_TLBL || code == C_TLBS) && refill && !exl)
      offs = '0;
    else
      offs = W'(32'h180);
  end

  always_comb begin
    case (kind)
      K_RST:   vec = BOOT_RST;
      K_DBG:   vec = BOOT_DBG;
      default: vec = base + offs;
    endcase
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [5:0]        exc_id,
  input  logic [W-1:0]      pc,
  input  logic              in_dslot,
  input  logic [1:0]        cop_num,
  input  logic              tlb_refill,
  input  logic              exl_in,
  input  logic              erl_in,
  input  logic              bev_in,
  input  logic              iv_in,
  input  logic              dm_in,
  input  logic              kmode_in,
  input  logic [W-1:0]      ebase,
  output logic [W-1:0]      next_pc,
  output logic [W-1:0]      epc,
  output logic [W-1:0]      err_epc,
  output logic [W-1:0]      dbg_epc,
  output logic [4:0]        exc_code,
  output logic [1:0]        cop_err,
  output logic              bd,
  output logic              exl_out,
  output logic              erl_out,
  output logic              bev_out,
  output logic              dm_out,
  output logic              kmode_out,
  output logic              nmi_flag,
  output logic              srst_flag,
  output logic [5:0]        dbg_flags,
  output logic              taken,
  output logic              bad_id
);
  exc_kind_e           kind;
  logic [CODE_W-1:0]   code;
  logic [DBGIX_W-1:0]  dbg_idx;
  logic                is_srst, is_dss;
  logic [W-1:0]        vec, ret_adj;

  exc_decode u_dec (
    .id(exc_id), .dm_in(dm_in), .kind(kind), .code(code),
    .dbg_idx(dbg_idx), .is_srst(is_srst), .is_dss(is_dss)
  );

  exc_vector #(.W(W)) u_vec (
    .kind(kind), .code(code), .bev(bev_in), .iv(iv_in), .exl(exl_in),
    .refill(tlb_refill), .ebase(ebase), .vec(vec)
  );

  assign ret_adj = in_dslot ? (pc - W'(4)) : pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc   <= '0;
      epc       <= '0;
      err_epc   <= '0;
      dbg_epc   <= '0;
      exc_code  <= '0;
      cop_err   <= '0;
      bd        <= 1'b0;
      exl_out   <= 1'b0;
      erl_out   <= 1'b0;
      bev_out   <= 1'b0;
      dm_out    <= 1'b0;
      kmode_out <= 1'b0;
      nmi_flag  <= 1'b0;
      srst_flag <= 1'b0;
      dbg_flags <= '0;
      taken     <= 1'b0;
      bad_id    <= 1'b0;
    end else begin
      taken  <= 1'b0;
      bad_id <= 1'b0;
      if (exc_valid) begin
        case (kind)
          K_BAD: bad_id <= 1'b1;
          K_GEN: begin
            taken    <= 1'b1;
            next_pc  <= vec;
            exc_code <= code;
            if (code == C_CPU) cop_err <= cop_num;
            if (!exl_in) begin
              epc       <= ret_adj;
              bd        <= in_dslot;
              kmode_out <= 1'b1;
            end else begin
              kmode_out <= kmode_in;
            end
            exl_out <= 1'b1;
            erl_out <= erl_in;
            bev_out <= bev_in;
            dm_out  <= dm_in;
          end
          K_RST: begin
            taken     <= 1'b1;
            next_pc   <= vec;
            err_epc   <= ret_adj;
            exl_out   <= exl_in;
            erl_out   <= 1'b1;
            bev_out   <= 1'b1;
            dm_out    <= dm_in;
            kmode_out <= 1'b1;
            if (is_srst) srst_flag <= 1'b1;
            else         nmi_flag  <= 1'b1;
            if (!exl_in) bd <= 1'b0;
          end
          default: begin
            taken              <= 1'b1;
            next_pc            <= vec;
            dbg_epc            <= is_dss ? pc : ret_adj;
            dbg_flags[dbg_idx] <= 1'b1;
            exl_out            <= exl_in;
            erl_out            <= erl_in;
            bev_out            <= bev_in;
            dm_out             <= 1'b1;
            kmode_out          <= 1'b1;
            if (!exl_in) bd <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exc_valid,
  input logic [5:0]   exc_id,
  input logic [W-1:0] pc,
  input logic         in_dslot,
  input logic         exl_in,
  input logic         dm_in,
  input logic [W-1:0] next_pc,
  input logic [W-1:0] epc,
  input logic [W-1:0] dbg_epc,
  input logic [4:0]   exc_code,
  input logic         bd,
  input logic         erl_out,
  input logic         bev_out,
  input logic         dm_out,
  input logic         taken,
  input logic         bad_id
);
  assert_one_outcome_R14: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (taken || bad_id));

  assert_exclusive_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, bad_id}));

  assert_idle_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> (!taken && !bad_id));

  assert_reject_holds_R14: assert property (@(posedge clk) disable iff (!rst_n)
    bad_id |-> ($stable(next_pc) && $stable(epc) && $stable(exc_code)));

  assert_exl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exl_in) |=> ($stable(epc) && $stable(bd)));

  assert_nmi_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_id == 6'h20) |=> (next_pc == W'(32'hBFC0_0000) && erl_out && bev_out));

  assert_sstep_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_id == 6'h22) |=> (dbg_epc == $past(pc) && dm_out));

  assert_syscall_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_id == 6'd8) |=> (exc_code == 5'd8 && taken));

  assert_dm_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_id == 6'd0 && dm_in) |=> (next_pc == W'(32'hBFC0_0480) && $stable(exc_code)));

  assert_dslot_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_id == 6'd8 && !exl_in && in_dslot) |=> (bd && epc == $past(pc) - W'(4)));
endmodule

bind exc_entry_unit exc_entry_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_id(exc_id), .pc(pc),
  .in_dslot(in_dslot), .exl_in(exl_in), .dm_in(dm_in), .next_pc(next_pc),
  .epc(epc), .dbg_epc(dbg_epc), .exc_code(exc_code), .bd(bd),
  .erl_out(erl_out), .bev_out(bev_out), .dm_out(dm_out),
  .taken(taken), .bad_id(bad_id)
);

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_valid = 1'b0;
  logic [5:0] exc_id = '0;
  logic [31:0] pc = '0, ebase = '0;
  logic in_dslot = 0, tlb_refill = 0, exl_in = 0, erl_in = 0, bev_in = 0;
  logic iv_in = 0, dm_in = 0, kmode_in = 0;
  logic [1:0] cop_num = '0;

  logic [31:0] next_pc, epc, err_epc, dbg_epc;
  logic [4:0] exc_code;
  logic [1:0] cop_err;
  logic bd, exl_out, erl_out, bev_out, dm_out, kmode_out, nmi_flag, srst_flag;
  logic [5:0] dbg_flags;
  logic taken, bad_id;

  // 50 MHz: 20-unit period
  always #10 clk = ~clk;

  exc_entry_unit u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_pc, m_epc, m_eepc, m_depc;
  logic [4:0]  m_code;
  logic [1:0]  m_ce;
  logic m_bd, m_exl, m_erl, m_bev, m_dm, m_km, m_nmi, m_sr, m_tk, m_bad;
  logic [5:0]  m_dbg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit known(input logic [4:0] c);
    return (c <= 5'd13) || c == 5'd15 || c == 5'd18 ||
           (c >= 5'd22 && c <= 5'd25) || c == 5'd30;
  endfunction

  task automatic model_reset();
    m_pc = 0; m_epc = 0; m_eepc = 0; m_depc = 0; m_code = 0; m_ce = 0;
    m_bd = 0; m_exl = 0; m_erl = 0; m_bev = 0; m_dm = 0; m_km = 0;
    m_nmi = 0; m_sr = 0; m_dbg = 0; m_tk = 0; m_bad = 0;
  endtask

  task automatic model_step();
    logic [5:0] e;
    logic [31:0] ret, base, off;
    e = exc_id;
    if (e == 6'd0 && dm_in) e = 6'h23;
    ret = in_dslot ? pc - 32'd4 : pc;
    m_tk = 0; m_bad = 0;
    if (!e[5] && known(e[4:0])) begin
      m_tk = 1;
      base = bev_in ? 32'hBFC00200 : (ebase & 32'hFFFFFC00);
      if (e[4:0] == 5'd30) off = bev_in ? 32'h100 : 32'h20000100;
      else if (e[4:0] == 5'd0 && iv_in) off = 32'h200;
      else if ((e[4:0] == 5'd2 || e[4:0] == 5'd3) && tlb_refill && !exl_in) off = 32'h0;
      else off = 32'h180;
      m_pc = base + off;
      m_code = e[4:0];
      if (e[4:0] == 5'd11) m_ce = cop_num;
      if (!exl_in) begin m_epc = ret; m_bd = in_dslot; m_km = 1; end
      else m_km = kmode_in;
      m_exl = 1; m_erl = erl_in; m_bev = bev_in; m_dm = dm_in;
    end else if (e == 6'h20 || e == 6'h21) begin
      m_tk = 1; m_pc = 32'hBFC00000; m_eepc = ret;
      m_exl = exl_in; m_erl = 1; m_bev = 1; m_dm = dm_in; m_km = 1;
      if (e == 6'h21) m_sr = 1; else m_nmi = 1;
      if (!exl_in) m_bd = 0;
    end else if (e >= 6'h22 && e <= 6'h27) begin
      m_tk = 1; m_pc = 32'hBFC00480;
      m_depc = (e == 6'h22) ? pc : ret;
      m_dbg[e - 6'h22] = 1'b1;
      m_exl = exl_in; m_erl = erl_in; m_bev = bev_in; m_dm = 1; m_km = 1;
      if (!exl_in) m_bd = 0;
    end else begin
      m_bad = 1;
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " next_pc"}, next_pc, m_pc);
    chk({tag, " epc"}, epc, m_epc);
    chk({tag, " err_epc"}, err_epc, m_eepc);
    chk({tag, " dbg_epc"}, dbg_epc, m_depc);
    chk({tag, " exc_code"}, 32'(exc_code), 32'(m_code));
    chk({tag, " cop_err"}, 32'(cop_err), 32'(m_ce));
    chk({tag, " bd"}, 32'(bd), 32'(m_bd));
    chk({tag, " status"}, {27'd0, exl_out, erl_out, bev_out, dm_out, kmode_out},
        {27'd0, m_exl, m_erl, m_bev, m_dm, m_km});
    chk({tag, " flags"}, {24'd0, nmi_flag, srst_flag, dbg_flags}, {24'd0, m_nmi, m_sr, m_dbg});
    chk({tag, " pulses"}, {30'd0, taken, bad_id}, {30'd0, m_tk, m_bad});
  endtask

  // inputs are set at a negedge; strobe for one cycle; compare at the next negedge
  task automatic fire(input string tag);
    model_step();
    exc_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0;
    compare_all(tag);
  endtask

  task automatic setin(input logic [5:0] id, input logic [31:0] p, input logic ds,
                       input logic exl, input logic bev, input logic iv, input logic dm);
    exc_id = id; pc = p; in_dslot = ds; exl_in = exl; bev_in = bev; iv_in = iv; dm_in = dm;
  endtask

  function automatic logic [5:0] pick_id(input int unsigned r);
    case (r)
      0: return 6'd0;   1: return 6'd1;   2: return 6'd2;   3: return 6'd3;
      4: return 6'd4;   5: return 6'd5;   6: return 6'd6;   7: return 6'd7;
      8: return 6'd8;   9: return 6'd9;   10: return 6'd10; 11: return 6'd11;
      12: return 6'd12; 13: return 6'd13; 14: return 6'd15; 15: return 6'd18;
      16: return 6'd22; 17: return 6'd23; 18: return 6'd24; 19: return 6'd25;
      20: return 6'd30;
      21, 22, 23, 24, 25, 26, 27, 28: return 6'h20 + 6'(r - 21);
      29: return 6'd14; 30: return 6'd26; 31: return 6'h28;
      default: return 6'h3F;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset");

    ebase = 32'h8000_1234; kmode_in = 0; erl_in = 0; tlb_refill = 0; cop_num = 0;
    setin(6'd8, 32'h0040_0100, 0, 0, 0, 0, 0); fire("R2 syscall bev0");
    setin(6'd8, 32'h0040_0104, 0, 0, 1, 0, 0); fire("R2 syscall bev1");
    setin(6'd0, 32'h0040_0108, 0, 0, 0, 1, 0); fire("R3 irq iv1");
    setin(6'd0, 32'h0040_010C, 0, 0, 0, 0, 0); fire("R3 irq iv0");
    tlb_refill = 1;
    setin(6'd2, 32'h0040_0110, 0, 0, 0, 0, 0); fire("R4 refill load");
    setin(6'd3, 32'h0040_0114, 0, 0, 0, 0, 0); fire("R4 refill store");
    setin(6'd2, 32'h0040_0118, 1, 1, 0, 0, 0); fire("R4 R8 refill exl set");
    tlb_refill = 0;
    setin(6'd30, 32'h0040_011C, 0, 0, 1, 0, 0); fire("R5 cache bev1");
    setin(6'd30, 32'h0040_0120, 0, 0, 0, 0, 0); fire("R5 cache bev0");
    setin(6'd4, 32'h0040_0200, 1, 0, 0, 0, 0); fire("R7 dslot epc");
    setin(6'd5, 32'h0040_0300, 0, 1, 0, 0, 0); kmode_in = 0; fire("R8 exl held");
    cop_num = 2'd2;
    setin(6'd11, 32'h0040_0400, 0, 0, 0, 0, 0); fire("R9 cop unusable");
    cop_num = 2'd3;
    setin(6'd9, 32'h0040_0404, 0, 0, 0, 0, 0); fire("R9 cop held");
    setin(6'd10, 32'h0040_0500, 1, 0, 0, 0, 0); fire("R7 set bd");
    setin(6'h20, 32'h0040_0600, 1, 0, 0, 0, 0); fire("R10 R13 nmi");
    setin(6'h21, 32'h0040_0700, 0, 0, 0, 0, 0); fire("R10 soft reset");
    setin(6'd12, 32'h0040_0800, 1, 0, 0, 0, 0); fire("R7 set bd again");
    setin(6'h22, 32'h0040_0900, 1, 1, 0, 0, 0); fire("R11 R13 single step exl set");
    setin(6'h24, 32'h0040_0A00, 1, 0, 0, 0, 0); fire("R11 R13 ibreak");
    setin(6'd0, 32'h0040_0B00, 0, 0, 0, 1, 1); fire("R12 irq in debug");
    setin(6'd14, 32'h0040_0C00, 1, 0, 1, 0, 0); fire("R14 unknown code");
    setin(6'h28, 32'h0040_0C04, 0, 0, 0, 0, 0); fire("R14 unknown special");
    setin(6'd16, 32'h0040_0C08, 0, 0, 0, 0, 0); fire("R6 R14 hole code");

    for (int i = 0; i < 400; i++) begin
      exc_id     = pick_id($urandom % 34);
      pc         = $urandom & 32'hFFFF_FFFC;
      ebase      = $urandom;
      in_dslot   = 1'($urandom);
      cop_num    = 2'($urandom);
      tlb_refill = 1'($urandom);
      exl_in     = 1'($urandom);
      erl_in     = 1'($urandom);
      bev_in     = 1'($urandom);
      iv_in      = 1'($urandom);
      dm_in      = (($urandom % 4) == 0);
      kmode_in   = 1'($urandom);
      fire("R6 random");
      if (($urandom % 5) == 0) @(negedge clk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule